// File: doc/BRIEF.md
# Encoded Clock Divisor Tick Generator

This block divides the system clock down to a slow strobe, nominally 1 MHz, that paces every time slot of a serial bus master. The host writes an 8-bit setting. Three of its fields matter here:

- an enable flag;
- a two-bit odd pre-scale select;
- a three-bit power-of-two exponent.

The block produces a single-cycle tick enable at the system clock rate divided by the product of the two stages.

The setting is held in a register that is loaded on a write strobe. Each write restarts both counter stages, so the first tick after a write arrives a full period later. Software picks the setting from its known clock frequency. For example, a 112 MHz clock uses ÷7 × 2^4, and a 128 MHz clock uses ÷1 × 2^7.

Top module: `clkdiv_tick`

## Requirements
- R1: While reset is asserted and after it is released, the tick output is low, and the stored setting is zero, which means disabled.
- R2: Setting bits 1:0 select the pre-scale ratio: code 0 gives ÷1, code 1 gives ÷3, code 2 gives ÷5 and code 3 gives ÷7.
- R3: Setting bits 4:2 hold an exponent n from 0 to 7 that adds a further ÷2^n after the pre-scaler.
- R4: With the enable bit set, the first tick comes exactly P·2^n clock cycles after the write edge, and ticks repeat every P·2^n cycles after that. For example, 0x80 gives 1, 0x8C gives 8, 0x93 gives 112 and 0x9C gives 128.
- R5: When setting bit 7 (enable) is clear, both counters are held at zero and no tick is produced.
- R6: Any write restarts both stages, even a write of the same value. The next tick comes exactly P·2^n cycles after that write.
- R7: Each tick is high for exactly one clock cycle when the ratio is greater than one.
- R8: Setting bits 6:5 have no effect on the tick timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_in | input | 8 | Divisor setting: bit 7 enable, bits 4:2 exponent, bits 1:0 pre-scale code |
| cfg_wr | input | 1 | Loads cfg_in and restarts both stages |
| tick_o | output | 1 | Registered one-cycle tick enable |

## Verification
The hardest case to reach from the ports is a restart in the middle of a period. A write arrives while both counters hold non-zero counts. The bench starts a ÷8 setting and lets it run part way. It then rewrites the same value and checks that the next tick is timed from the second write, not the first. The longest ratio, ÷7 × 2^7, exercises the full width of the binary stage. The measured gap between ticks also confirms that the pulse drops after one cycle.

// File: rtl/clkdiv_tick_pkg.sv
package clkdiv_tick_pkg;
  localparam int CFG_W    = 8;
  localparam int CODE_W   = 2;
  localparam int EXP_W    = 3;
  localparam int EN_BIT   = 7;
  localparam int EXP_LSB  = CODE_W;
  localparam int PRE_CW   = CODE_W + 1;
  localparam int BIN_CW   = (1 << EXP_W) - 1;

  typedef struct packed {
    logic              en;
    logic [EXP_W-1:0]  expo;
    logic [CODE_W-1:0] code;
  } div_cfg_t;
endpackage

// File: rtl/clkdiv_prescale.sv
module clkdiv_prescale #(
  parameter int CODE_W = 2,
  parameter int CNT_W  = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  cnt,
  output logic              pulse
);
  // odd length 2*code+1: terminal count is 2*code
  logic [CNT_W-1:0] last;
  assign last  = {code, 1'b0};
  assign pulse = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt <= '0;
    else if (pulse)         cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/clkdiv_bindiv.sv
module clkdiv_bindiv #(
  parameter int EXP_W = 3,
  parameter int CNT_W = (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             step,
  input  logic [EXP_W-1:0] expo,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // terminal count 2^n - 1 as a thermometer mask
  always_comb begin
    for (int i = 0; i < CNT_W; i++) last[i] = (i < int'(expo));
  end

  assign done = step && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt <= '0;
    else if (done)          cnt <= '0;
    else if (step)          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/clkdiv_tick.sv
module clkdiv_tick
  import clkdiv_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_in,
  input  logic             cfg_wr,
  output logic             tick_o
);
  div_cfg_t          cfg_q;
  logic [PRE_CW-1:0] pre_cnt;
  logic              pre_pulse;
  logic              bin_done;
  logic              unused_cfg;

  assign unused_cfg = ^cfg_in[EN_BIT-1:EXP_LSB+EXP_W];

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_wr) cfg_q <= '{en:   cfg_in[EN_BIT],
                               expo: cfg_in[EXP_LSB +: EXP_W],
                               code: cfg_in[CODE_W-1:0]};
  end

  clkdiv_prescale #(.CODE_W(CODE_W), .CNT_W(PRE_CW)) u_pre (
    .clk(clk), .rst(rst), .clr(cfg_wr), .run(cfg_q.en),
    .code(cfg_q.code), .cnt(pre_cnt), .pulse(pre_pulse)
  );

  clkdiv_bindiv #(.EXP_W(EXP_W), .CNT_W(BIN_CW)) u_bin (
    .clk(clk), .rst(rst), .clr(cfg_wr), .run(cfg_q.en),
    .step(pre_pulse), .expo(cfg_q.expo), .done(bin_done)
  );

  always_ff @(posedge clk) begin
    if (rst || cfg_wr) tick_o <= 1'b0;
    else               tick_o <= bin_done;
  end
endmodule

// File: rtl/clkdiv_tick_chk.sv
module clkdiv_tick_chk
  import clkdiv_tick_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input div_cfg_t          cfg_q,
  input logic [PRE_CW-1:0] pre_cnt,
  input logic              tick_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !tick_o); // R1
  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= {cfg_q.code, 1'b0}); // R2
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.en |=> !tick_o); // R5
  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (!tick_o && pre_cnt == '0)); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !cfg_wr && (cfg_q.expo != '0 || cfg_q.code != '0)) |=> !tick_o); // R7
endmodule

bind clkdiv_tick clkdiv_tick_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_q(cfg_q),
  .pre_cnt(pre_cnt), .tick_o(tick_o)
);

// File: tb/clkdiv_tick_tb.sv
module clkdiv_tick_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_in = '0;
  logic       cfg_wr = 1'b0;
  logic       tick_o;
  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  clkdiv_tick u_dut (.clk(clk), .rst(rst), .cfg_in(cfg_in), .cfg_wr(cfg_wr), .tick_o(tick_o));

  localparam int NV = 9;
  localparam logic [7:0] VEC_CFG [NV] = '{8'h80, 8'h81, 8'h82, 8'h83, 8'h8C, 8'h93, 8'h9C, 8'hE5, 8'h9F};
  localparam int VEC_RATIO [NV] = '{1, 3, 5, 7, 8, 112, 128, 6, 896};
  localparam string VEC_REQ [NV] = '{"R4", "R2", "R2", "R2", "R3", "R4", "R3", "R8", "R4"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_in = v; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  // cycles from the last sampled point until tick is seen high
  task automatic gap(output int n, input int limit);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_o && n < limit);
    if (!tick_o) n = -1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    int hits;
    repeat (3) @(negedge clk);
    check(tick_o == 1'b0, "R1", tick_o, 0);
    rst = 1'b0;
    hits = 0;
    repeat (30) begin @(negedge clk); if (tick_o) hits++; end
    check(hits == 0, "R1", hits, 0);

    for (int v = 0; v < NV; v++) begin
      write_cfg(VEC_CFG[v]);
      gap(n, 2000);
      check(n == VEC_RATIO[v], VEC_REQ[v], n, VEC_RATIO[v]);
      gap(n, 2000);
      check(n == VEC_RATIO[v], VEC_REQ[v], n, VEC_RATIO[v]);
      if (VEC_RATIO[v] > 1) begin
        @(negedge clk);
        check(tick_o == 1'b0, "R7", tick_o, 0);
      end
    end

    // R5: enable clear, settings otherwise nonzero
    write_cfg(8'h1D);
    hits = 0;
    repeat (1000) begin @(negedge clk); if (tick_o) hits++; end
    check(hits == 0, "R5", hits, 0);

    // R6: rewrite same value mid-period
    write_cfg(8'h8C);
    repeat (5) @(negedge clk);
    check(tick_o == 1'b0, "R6", tick_o, 0);
    write_cfg(8'h8C);
    gap(n, 2000);
    check(n == 8, "R6", n, 8);

    // R6: switch ratio mid-period, 3 -> 7*2
    write_cfg(8'h81);
    @(negedge clk);
    write_cfg(8'h87);
    gap(n, 2000);
    check(n == 14, "R6", n, 14);

    // R1: reset mid-run silences output
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(tick_o == 1'b0, "R1", tick_o, 0);
    rst = 1'b0;
    hits = 0;
    repeat (40) begin @(negedge clk); if (tick_o) hits++; end
    check(hits == 0, "R1", hits, 0);

    finish_run();
  end
endmodule